// File: doc/BRIEF.md
# Saturating Element Clamp

This block sits at the end of a vector datapath, after the arithmetic unit. Each valid cycle it takes one wide signed intermediate result and limits it to the range of the chosen destination element width. The caller picks the width and whether the range is unsigned or two's-complement signed. The clamp is done at the full intermediate width and only then reduced to the destination width. A value far outside the range therefore saturates and does not wrap.

When the record-condition enable is set, every element gets its own 4-bit condition field. That field describes the sign of the clamped value and carries an overflow bit that is set only when this one element was clamped. The block has no global or sticky flag of any kind. An operation that also produces a carry-out cannot be saturated, because the carry would need the same condition bit. Such an element is rejected and flagged as illegal.

Results leave the block one clock after they enter, with a valid strobe and no backpressure.

Top module: `sat_clamp_elem`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. Each accepted element shows up on the outputs in the cycle after the edge that captured it.
- R2: `in_wsel` selects the destination width: 0 → 8, 1 → 16, 2 → 32, 3 → 64 bits. With `in_signed`=0 the result is clamped to 0 … 2^W−1 and zero-extended to 64 bits. A negative input gives 0.
- R3: With `in_signed`=1 the result is clamped to −2^(W−1) … 2^(W−1)−1 and sign-extended to 64 bits.
- R4: The comparison uses every bit of the intermediate value, not a truncated copy. An in-range value passes through unchanged, and a value with bits set above bit 63 still saturates.
- R5: When `in_rc`=1, bit 0 of `out_cond` is 1 exactly when that element was clamped, and 0 otherwise.
- R6: The overflow bit never accumulates. An unclamped element that follows a clamped one reports overflow 0.
- R7: When `in_rc`=1, bit 3 = less-than-zero, bit 2 = greater-than-zero and bit 1 = equal-to-zero, all taken from the clamped value. Exactly one of these three bits is set. In unsigned mode bit 3 is always 0.
- R8: When `in_rc`=0, `out_cond` is 0 and `out_cond_we` is 0.
- R9: An element with `in_carry_op`=1 sets `out_illegal` and outputs element 0, condition 0 and `out_cond_we`=0.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Element strobe |
| in_value | input | ACC_W (72) | Signed intermediate result |
| in_signed | input | 1 | 1 selects a signed range, 0 an unsigned range |
| in_wsel | input | SEL_W (2) | Destination width code |
| in_rc | input | 1 | Record-condition enable |
| in_carry_op | input | 1 | The operation also produces a carry-out |
| out_valid | output | 1 | Result strobe |
| out_elem | output | MAX_W (64) | Clamped element, extended to 64 bits |
| out_cond | output | 4 | {lt, gt, eq, ov} |
| out_cond_we | output | 1 | Condition field write enable |
| out_illegal | output | 1 | Saturation combined with a carry-out |

## Verification
The in-RTL assertions check the following on every cycle:
- the one-cycle valid delay;
- that the condition bits are one-hot when written;
- that an unclamped element equals the low 64 input bits;
- that upper bits are zero in unsigned mode;
- the quiet outputs under Rc=0 and under the illegal carry combination.

Only the bench scenarios can show the rest:
- the exact saturation values at each width and sign mode;
- exact-boundary inputs that must not flag overflow;
- wide inputs above bit 63;
- an overflow followed by a clean element.

// File: rtl/sat_clamp_pkg.sv
`timescale 1ns/1ps
package sat_clamp_pkg;

   // Packed order is behaviour: bit3 lt, bit2 gt, bit1 eq, bit0 ov
   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic ov;
   } cond_t;

endpackage

// File: rtl/sat_bound.sv
`timescale 1ns/1ps
// Range limiter for one destination width, evaluated at full intermediate width
module sat_bound #(
   parameter int ACC_W = 72,
   parameter int W     = 8,
   parameter int OUT_W = 64
) (
   input  logic signed [ACC_W-1:0] value,
   input  logic                    is_signed,
   output logic [OUT_W-1:0]        clamped,
   output logic                    hit
);

   localparam logic signed [ACC_W-1:0] U_HI = {{(ACC_W-W){1'b0}}, {W{1'b1}}};
   localparam logic signed [ACC_W-1:0] S_HI = {{(ACC_W-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] S_LO = {{(ACC_W-W+1){1'b1}}, {(W-1){1'b0}}};

   logic signed [ACC_W-1:0] hi, lo, picked;
   logic                    above, below;

   always_comb begin
      hi     = is_signed ? S_HI : U_HI;
      lo     = is_signed ? S_LO : '0;
      above  = value > hi;
      below  = value < lo;
      hit    = above | below;
      picked = above ? hi : (below ? lo : value);
   end

   assign clamped = picked[OUT_W-1:0];

endmodule

// File: rtl/sat_cond.sv
`timescale 1ns/1ps
// Per-element condition field from the clamped value
module sat_cond
   import sat_clamp_pkg::*;
#(
   parameter int OUT_W = 64
) (
   input  logic [OUT_W-1:0] elem,
   input  logic             is_signed,
   input  logic             hit,
   input  logic             rc_en,
   output cond_t            cond
);

   logic neg, zero;

   assign neg  = is_signed & elem[OUT_W-1];
   assign zero = (elem == '0);

   always_comb begin
      cond = '0;
      if (rc_en) begin
         cond.lt = neg;
         cond.eq = zero;
         cond.gt = ~neg & ~zero;
         cond.ov = hit;
      end
   end

endmodule

// File: rtl/sat_clamp_elem.sv
`timescale 1ns/1ps
module sat_clamp_elem
   import sat_clamp_pkg::*;
#(
   parameter int ACC_W    = 72,
   parameter int MIN_W    = 8,
   parameter int N_WIDTHS = 4,
   localparam int MAX_W   = MIN_W << (N_WIDTHS-1),
   localparam int SEL_W   = (N_WIDTHS > 1) ? $clog2(N_WIDTHS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [ACC_W-1:0] in_value,
   input  logic                    in_signed,
   input  logic [SEL_W-1:0]        in_wsel,
   input  logic                    in_rc,
   input  logic                    in_carry_op,
   output logic                    out_valid,
   output logic [MAX_W-1:0]        out_elem,
   output logic [3:0]              out_cond,
   output logic                    out_cond_we,
   output logic                    out_illegal
);

   initial begin
      assert (ACC_W > MAX_W)
         else $error("ACC_W must exceed the widest destination width");
      assert (N_WIDTHS >= 1 && MIN_W >= 2)
         else $error("width set parameters out of range");
   end

   logic [MAX_W-1:0] cand     [N_WIDTHS];
   logic             cand_hit [N_WIDTHS];

   for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
      sat_bound #(
         .ACC_W (ACC_W),
         .W     (MIN_W << g),
         .OUT_W (MAX_W)
      ) u_bound (
         .value     (in_value),
         .is_signed (in_signed),
         .clamped   (cand[g]),
         .hit       (cand_hit[g])
      );
   end

   logic [SEL_W-1:0] sel_idx;
   logic [MAX_W-1:0] pick;
   logic             pick_hit;
   cond_t            cond_d;

   assign sel_idx  = (int'(in_wsel) < N_WIDTHS) ? in_wsel : SEL_W'(N_WIDTHS-1);
   assign pick     = cand[sel_idx];
   assign pick_hit = cand_hit[sel_idx];

   sat_cond #(.OUT_W(MAX_W)) u_cond (
      .elem      (pick),
      .is_signed (in_signed),
      .hit       (pick_hit),
      .rc_en     (in_rc),
      .cond      (cond_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_elem    <= '0;
         out_cond    <= '0;
         out_cond_we <= 1'b0;
         out_illegal <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_cond_we <= in_valid & in_rc & ~in_carry_op;
         out_illegal <= in_valid & in_carry_op;
         if (in_valid) begin
            out_elem <= in_carry_op ? '0 : pick;
            out_cond <= in_carry_op ? 4'b0 : cond_d;
         end
      end
   end

   // Observation helpers for the properties below
   logic [MAX_W-1:0] low_in;
   logic [31:0]      sel_bits;
   assign low_in   = in_value[MAX_W-1:0];
   assign sel_bits = 32'(MIN_W) << in_wsel;

   p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_unsigned_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal && !$past(in_signed)) |->
         ((out_elem >> $past(sel_bits)) == '0));
   p_clean_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_cond_we && !out_cond[0]) |-> (out_elem == $past(low_in)));
   p_cond_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_cond_we |-> ($countones(out_cond[3:1]) == 1));
   p_unsigned_no_lt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_cond_we && !$past(in_signed)) |-> !out_cond[3]);
   p_rc_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(in_rc)) |-> (out_cond == 4'b0 && !out_cond_we));
   p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (!out_cond_we && out_elem == '0 && out_cond == 4'b0));
   p_we_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_cond_we || out_illegal) |-> out_valid);

endmodule

// File: tb/sat_clamp_elem_bench.sv
`timescale 1ns/1ps
module sat_clamp_elem_bench;

   localparam int ACC_W = 72;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic signed [ACC_W-1:0] in_value = '0;
   logic                    in_signed = 1'b0;
   logic [1:0]              in_wsel = '0;
   logic                    in_rc = 1'b0;
   logic                    in_carry_op = 1'b0;
   logic                    out_valid;
   logic [63:0]             out_elem;
   logic [3:0]              out_cond;
   logic                    out_cond_we;
   logic                    out_illegal;

   int    checks = 0;
   int    failures = 0;
   bit    chk_en = 1'b0;
   string tag = "R10";

   always #4 clk = ~clk;   // 125 MHz

   sat_clamp_elem u_sat_clamp_elem (
      .clk, .rst_n, .in_valid, .in_value, .in_signed, .in_wsel,
      .in_rc, .in_carry_op, .out_valid, .out_elem, .out_cond,
      .out_cond_we, .out_illegal
   );

   task automatic model(input logic signed [ACC_W-1:0] v, input logic sg,
                        input logic [1:0] ws, input logic rc, input logic cy,
                        output logic [63:0] e, output logic [3:0] c,
                        output logic we, output logic ill);
      logic signed [127:0] x, hi, lo, r;
      int w;
      logic ov;
      w  = 8 << ws;
      x  = v;
      hi = sg ? (128'sd1 <<< (w-1)) - 128'sd1 : (128'sd1 <<< w) - 128'sd1;
      lo = sg ? -(128'sd1 <<< (w-1)) : 128'sd0;
      ov = (x > hi) || (x < lo);
      r  = (x > hi) ? hi : ((x < lo) ? lo : x);
      if (cy) begin
         e = '0; c = '0; we = 1'b0; ill = 1'b1;
      end else begin
         e   = r[63:0];
         c   = rc ? {r < 0, r > 0, r == 0, ov} : 4'b0;
         we  = rc;
         ill = 1'b0;
      end
   endtask

   // Reference comparison on every clock, 2 ns after the rising edge
   always @(posedge clk) begin
      logic        vi, sgi, rci, cyi;
      logic [1:0]  wsi;
      logic signed [ACC_W-1:0] vv;
      logic [63:0] e;
      logic [3:0]  c;
      logic        we, ill;
      vi = in_valid; sgi = in_signed; rci = in_rc; cyi = in_carry_op;
      wsi = in_wsel; vv = in_value;
      #2;
      if (chk_en) begin
         checks++;
         if (vi) begin
            model(vv, sgi, wsi, rci, cyi, e, c, we, ill);
            if (out_valid !== 1'b1 || out_elem !== e || out_cond !== c ||
                out_cond_we !== we || out_illegal !== ill) begin
               failures++;
               $display("FAIL %s: actual v=%b e=%h c=%b we=%b ill=%b expected v=1 e=%h c=%b we=%b ill=%b",
                        tag, out_valid, out_elem, out_cond, out_cond_we, out_illegal,
                        e, c, we, ill);
            end
         end else if (out_valid !== 1'b0 || out_cond_we !== 1'b0 || out_illegal !== 1'b0) begin
            failures++;
            $display("FAIL R1 idle: actual v=%b we=%b ill=%b expected 0 0 0",
                     out_valid, out_cond_we, out_illegal);
         end
      end
   end

   task automatic send(input logic signed [ACC_W-1:0] v, input logic sg,
                       input logic [1:0] ws, input logic rc, input logic cy,
                       input string t);
      @(negedge clk);
      in_valid = 1'b1; in_value = v; in_signed = sg; in_wsel = ws;
      in_rc = rc; in_carry_op = cy; tag = t;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_value = '0; tag = "R1";
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;   // R10 reset state
      if (out_valid !== 1'b0 || out_elem !== '0 || out_cond !== '0 ||
          out_cond_we !== 1'b0 || out_illegal !== 1'b0) begin
         failures++;
         $display("FAIL R10: actual v=%b e=%h c=%b we=%b ill=%b expected all zero",
                  out_valid, out_elem, out_cond, out_cond_we, out_illegal);
      end
      rst_n = 1'b1;
      chk_en = 1'b1;
      idle();
      // R2 unsigned clamping at 8 bits
      send(72'sd300, 0, 0, 1, 0, "R2");
      send(-72'sd5,  0, 0, 1, 0, "R2");
      send(72'sd100, 0, 0, 1, 0, "R2");
      send(72'sd255, 0, 0, 1, 0, "R2");
      // R3 signed clamping
      send(72'sd200,   1, 0, 1, 0, "R3");
      send(-72'sd200,  1, 0, 1, 0, "R3");
      send(-72'sd128,  1, 0, 1, 0, "R3");
      send(-72'sd1234, 1, 1, 1, 0, "R3");
      send(72'sd40000, 1, 1, 1, 0, "R3");
      send(72'sh1_0000_0000, 1, 2, 1, 0, "R3");
      idle();
      // R4 wide evaluation, 64-bit boundaries
      send(72'sh1_0000_0000_0000_0005, 0, 3, 1, 0, "R4");
      send(72'sh0_FFFF_FFFF_FFFF_FFFF, 0, 3, 1, 0, "R4");
      send(72'sh100_0000_0005, 0, 0, 1, 0, "R4");
      send(-72'sh8000_0000_0000_0000, 1, 3, 1, 0, "R4");
      send(-72'sh8000_0000_0000_0001, 1, 3, 1, 0, "R4");
      send(72'sh7FFF_FFFF_FFFF_FFFF, 1, 3, 1, 0, "R4");
      // R5 / R6 overflow per element, never sticky
      send(72'sd70000, 0, 1, 1, 0, "R5");
      send(72'sd7,     0, 1, 1, 0, "R6");
      send(-72'sd9,    1, 2, 1, 0, "R6");
      // R7 zero and sign encodings
      send(72'sd0,  1, 2, 1, 0, "R7");
      send(72'sd0,  0, 3, 1, 0, "R7");
      send(-72'sd3, 0, 1, 1, 0, "R7");
      // R8 record disabled
      send(72'sd300,  0, 0, 0, 0, "R8");
      send(-72'sd50,  1, 0, 0, 0, "R8");
      // R9 saturation with carry-out rejected
      send(72'sd300, 0, 0, 1, 1, "R9");
      send(72'sd12,  1, 1, 0, 1, "R9");
      send(72'sd12,  1, 1, 1, 0, "R9");
      idle();
      idle();
      // R1 stream with gaps
      for (int i = 0; i < 16; i++) begin
         if (i % 5 == 4) idle();
         else send(ACC_W'(i * 37) - 72'sd250, 1'(i % 2), 2'(i % 4), 1'(i % 3 != 0), 0, "R1");
      end
      idle();
      idle();
      @(posedge clk);
      #3;
      chk_en = 1'b0;
      finish_run();
   end

endmodule